// File: doc/BRIEF.md
# Quasi-Resonant Turn-On Sequencer

This block decides, cycle by cycle, when the power switch of a quasi-resonant flyback converter is turned on, and when the peak-current comparator may turn it off. It works on digitized comparator flags from the transformer demagnetization sense input. One flag is high while the sense voltage is above the arming level. The other is high while the sense voltage is below the trigger level, so its rising edge marks a falling crossing, which is a ringing valley. A blanking-time code, derived elsewhere from the error-amplifier level, sets how many cycles after each turn-off valleys are ignored. This skips valleys at light load and bounds the switching frequency.

When no valley edge arrives, for example at power-up or when the output is too low to arm the trigger, a free-running starter turns the switch on by itself. It runs at a slow rate while the control level is below the burst threshold and at a fast rate above it. Each valley turn-on restarts the starter, so it stays silent while valley-locked switching continues.

After every turn-on, the current-limit window is held closed for a short leading-edge blanking interval. Once the window opens, a current-limit trip ends the on-time. Every interface is plain level control. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `qrs_turnon_seq`

## Requirements
- R1: While reset is asserted, gate_on and cs_window are 0. After reset, the trigger is disarmed and no blanking interval is running.
- R2: A rising edge of arm_cross arms the trigger while gate_on is 0. A rising edge of trig_cross on a disarmed trigger does not turn the switch on.
- R3: With en high, gate_on low, the trigger armed and no blanking interval running, a rising edge of trig_cross seen in a cycle sets gate_on at the next clock edge.
- R4: Every turn-on, valley or starter, disarms the trigger. The next valley turn-on needs a fresh arm_cross rising edge.
- R5: When gate_on falls, a blanking interval of B = max(blank_code, BLANK_MIN) cycles starts. Counting the first cycle with gate_on low as cycle 0, trig_cross rising edges in cycles 0 to B-1 are ignored and are not remembered. A rising edge in cycle B or later is accepted.
- R6: blank_code values below BLANK_MIN are raised to BLANK_MIN. Two turn-ons are therefore never closer than BLANK_MIN cycles apart, which caps the switching frequency.
- R7: With gate_on and cs_window high, ilim_trip high in a cycle clears gate_on at the next edge.
- R8: cs_window is low for the first LEB cycles of each on-time and high after that while gate_on is high. An ilim_trip during the closed window has no effect.
- R9: If P cycles have passed since the last turn-on, with gate_on low and en high, the starter turns the switch on at that edge. P is ST_SLOW while burst_low is 1 and ST_FAST while it is 0.
- R10: A valley turn-on restarts the starter period from zero.
- R11: With en low, gate_on is cleared at the next edge. No turn-on of either kind happens, the trigger is disarmed, blanking is cancelled and the starter is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low forces the switch off |
| arm_cross | input | 1 | High while the sense voltage is above the arming level |
| trig_cross | input | 1 | High while the sense voltage is below the trigger level |
| blank_code | input | BLANK_W | Valley blanking time in clock cycles |
| burst_low | input | 1 | Control level is below the burst threshold (slow starter) |
| ilim_trip | input | 1 | Peak-current comparator has tripped |
| gate_on | output | 1 | Power switch on request |
| cs_window | output | 1 | Current-limit comparison enabled |

## Verification
The hardest situation to reach from the ports is a valley edge placed exactly on the last blanked cycle or on the first open cycle. The length of that interval is recomputed from blank_code at every turn-off and may be raised to the floor. The stimulus counts cycles from the observed falling edge of gate_on and places a fresh arm pulse and a trigger edge at a chosen offset. It covers directed offsets at B-1 and B, codes under the floor, and random code/offset pairs. A rejected edge is followed by a later edge, which shows that the rejection left no remembered trigger behind. Starter timing is reached by letting the sense flags stay quiet for a full period after a known turn-on, and also after a valley turn-on part way through a period.

// File: rtl/qrs_pkg.sv
package qrs_pkg;
  localparam int unsigned DEF_BLANK_W   = 9;
  localparam int unsigned DEF_BLANK_MIN = 61;
  localparam int unsigned DEF_LEB       = 3;
  localparam int unsigned DEF_ST_SLOW   = 5000;
  localparam int unsigned DEF_ST_FAST   = 1250;

  typedef enum logic [1:0] {
    FLAG_TRIG = 2'd0,
    FLAG_ARM  = 2'd1
  } flag_idx_e;
endpackage

// File: rtl/qrs_rise_det.sv
module qrs_rise_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~q;
  end
endmodule

// File: rtl/qrs_downcnt.sv
module qrs_downcnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/qrs_starter.sv
module qrs_starter #(
  parameter int unsigned ST_SLOW = 5000,
  parameter int unsigned ST_FAST = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic restart,
  input  logic slow_sel,
  output logic fire
);
  localparam int unsigned W = $clog2(ST_SLOW + 1);
  localparam logic [W-1:0] LIM_SLOW = W'(ST_SLOW - 1);
  localparam logic [W-1:0] LIM_FAST = W'(ST_FAST - 1);

  logic [W-1:0] cnt;
  logic [W-1:0] limit;

  assign limit = slow_sel ? LIM_SLOW : LIM_FAST;
  assign fire  = en && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!en || restart)    cnt <= '0;
    else if (cnt != LIM_SLOW)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/qrs_turnon_seq.sv
module qrs_turnon_seq
  import qrs_pkg::*;
#(
  parameter int unsigned BLANK_W   = DEF_BLANK_W,
  parameter int unsigned BLANK_MIN = DEF_BLANK_MIN,
  parameter int unsigned LEB       = DEF_LEB,
  parameter int unsigned ST_SLOW   = DEF_ST_SLOW,
  parameter int unsigned ST_FAST   = DEF_ST_FAST
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               arm_cross,
  input  logic               trig_cross,
  input  logic [BLANK_W-1:0] blank_code,
  input  logic               burst_low,
  input  logic               ilim_trip,
  output logic               gate_on,
  output logic               cs_window
);
  localparam int unsigned LEB_W = $clog2(LEB + 1);
  localparam logic [BLANK_W-1:0] BMIN = BLANK_W'(BLANK_MIN);

  logic [1:0]         rise;
  logic               arm_rise, trig_rise;
  logic               gate_q, armed_q;
  logic               blank_zero, leb_zero, st_fire;
  logic               turn_on, turn_off;
  logic [BLANK_W-1:0] eff_blank;

  qrs_rise_det #(.N(2)) u_edges (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({arm_cross, trig_cross}),
    .rise (rise)
  );
  assign arm_rise  = rise[FLAG_ARM];
  assign trig_rise = rise[FLAG_TRIG];

  // Floor on the blanking time bounds the switching frequency (R6).
  assign eff_blank = (blank_code < BMIN) ? BMIN : blank_code;

  qrs_downcnt #(.W(BLANK_W)) u_blank (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (~en),
    .load    (turn_off),
    .load_val(eff_blank),
    .zero    (blank_zero)
  );

  qrs_downcnt #(.W(LEB_W)) u_leb (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (~en),
    .load    (turn_on),
    .load_val(LEB_W'(LEB)),
    .zero    (leb_zero)
  );

  qrs_starter #(.ST_SLOW(ST_SLOW), .ST_FAST(ST_FAST)) u_starter (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .restart (turn_on),
    .slow_sel(burst_low),
    .fire    (st_fire)
  );

  assign cs_window = gate_q & leb_zero;
  assign turn_on   = en & ~gate_q & ((trig_rise & armed_q & blank_zero) | st_fire);
  assign turn_off  = en & cs_window & ilim_trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (!en) begin
      gate_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (turn_on)       gate_q <= 1'b1;
      else if (turn_off) gate_q <= 1'b0;

      if (turn_on)                  armed_q <= 1'b0;
      else if (arm_rise && !gate_q) armed_q <= 1'b1;
    end
  end

  assign gate_on = gate_q;
endmodule

// File: rtl/qrs_turnon_seq_chk.sv
module qrs_turnon_seq_chk #(
  parameter int unsigned BLANK_MIN = 61,
  parameter int unsigned LEB       = 3
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic ilim_trip,
  input logic gate_on,
  input logic cs_window
);
  localparam int unsigned AW = $clog2(LEB + 2);
  localparam int unsigned SW = $clog2(BLANK_MIN + 2);
  localparam logic [AW-1:0] AMAX = AW'(LEB + 1);
  localparam logic [SW-1:0] SMAX = SW'(BLANK_MIN + 1);

  logic [AW-1:0] on_age;
  logic [SW-1:0] since_rise;
  logic          gate_d, seen_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_age     <= '0;
      since_rise <= '0;
      gate_d     <= 1'b0;
      seen_rise  <= 1'b0;
    end else begin
      gate_d <= gate_on;
      if (!gate_on)            on_age <= '0;
      else if (on_age != AMAX) on_age <= on_age + 1'b1;
      if (gate_on && !gate_d) begin
        since_rise <= '0;
        seen_rise  <= 1'b1;
      end else if (since_rise != SMAX) begin
        since_rise <= since_rise + 1'b1;
      end
    end
  end

  assert_leb_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_window |-> (gate_on && on_age >= AW'(LEB)));

  assert_leb_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on && !cs_window && en) |=> gate_on);

  assert_ilim_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on && cs_window && ilim_trip && en) |=> !gate_on);

  assert_disable_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !gate_on);

  assert_freq_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on && !gate_d && seen_rise) |-> (since_rise >= SW'(BLANK_MIN)));
endmodule

bind qrs_turnon_seq qrs_turnon_seq_chk #(.BLANK_MIN(BLANK_MIN), .LEB(LEB)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .ilim_trip(ilim_trip),
  .gate_on  (gate_on),
  .cs_window(cs_window)
);

// File: tb/qrs_turnon_seq_tb.sv
`timescale 1ns/1ps
module qrs_turnon_seq_tb;
  localparam int BW   = 9;
  localparam int BMIN = 61;
  localparam int LEB  = 3;
  localparam int SLOW = 5000;
  localparam int FAST = 1250;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, arm_cross = 1'b0, trig_cross = 1'b0, burst_low = 1'b1, ilim_trip = 1'b0;
  logic [BW-1:0] blank_code = '0;
  logic gate_on, cs_window;

  int nchk = 0, nerr = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  qrs_turnon_seq #(.BLANK_W(BW), .BLANK_MIN(BMIN), .LEB(LEB),
                   .ST_SLOW(SLOW), .ST_FAST(FAST)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .arm_cross(arm_cross),
    .trig_cross(trig_cross), .blank_code(blank_code), .burst_low(burst_low),
    .ilim_trip(ilim_trip), .gate_on(gate_on), .cs_window(cs_window));

  function automatic int eff_blank(input int code);
    return (code < BMIN) ? BMIN : code;
  endfunction

  function automatic int expect_accept(input int code, input int ofs);
    return (ofs >= eff_blank(code)) ? 1 : 0;
  endfunction

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) step();
  endtask

  // Ends an on-time through the current-limit window; returns at off cycle 0.
  task automatic to_off(input string req);
    while (!cs_window) step();
    ilim_trip = 1'b1;
    step();
    ilim_trip = 1'b0;
    chk(req, gate_on, 0);
  endtask

  // Valley trial: off, fresh arm, trigger edge at offset ofs from turn-off.
  // Leaves the switch on at cycle 0 of a valley on-time.
  task automatic trial(input int code, input int ofs, input string req);
    int t_off;
    blank_code = BW'(code);
    to_off(req);
    t_off = cyc;
    arm_cross = 1'b1;
    step();
    arm_cross = 1'b0;
    wait_to(t_off + ofs);
    trig_cross = 1'b1;
    step();
    trig_cross = 1'b0;
    chk(req, gate_on, expect_accept(code, ofs));
    if (!gate_on) begin
      step();
      wait_to(t_off + eff_blank(code) + 1);
      trig_cross = 1'b1;
      step();
      trig_cross = 1'b0;
      chk(req, gate_on, 1);
    end
  endtask

  initial begin
    #(4.0 * 190000);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int t_on, t2;
    void'($urandom(32'd4242));
    repeat (3) step();
    chk("R1 gate in reset", gate_on, 0);
    chk("R1 window in reset", cs_window, 0);
    rst_n = 1'b1;
    en = 1'b1;
    blank_code = BW'(100);
    step();

    // R2: trigger edge with no arming is ignored.
    trig_cross = 1'b1; step(); trig_cross = 1'b0;
    chk("R2 unarmed trigger", gate_on, 0);
    step();
    // R3: arm then trigger gives turn-on at next edge.
    arm_cross = 1'b1; step(); arm_cross = 1'b0;
    trig_cross = 1'b1; step(); trig_cross = 1'b0;
    chk("R3 valley turn-on", gate_on, 1);

    // R8 / R7: window closed for LEB cycles, trip ignored there.
    ilim_trip = 1'b1;
    for (int i = 0; i < LEB; i++) begin
      chk("R8 window closed", cs_window, 0);
      step();
    end
    chk("R8 trip ignored in blanking", gate_on, 1);
    chk("R8 window opens", cs_window, 1);
    step();
    ilim_trip = 1'b0;
    chk("R7 current-limit turn-off", gate_on, 0);

    // R4: arming is consumed by the turn-on.
    repeat (150) step();
    trig_cross = 1'b1; step(); trig_cross = 1'b0;
    chk("R4 no re-arm", gate_on, 0);
    step();
    arm_cross = 1'b1; step(); arm_cross = 1'b0;
    trig_cross = 1'b1; step(); trig_cross = 1'b0;
    chk("R4 re-armed turn-on", gate_on, 1);

    // R5 / R6 directed corners.
    trial(100, 99,  "R5 last blanked cycle");
    trial(100, 100, "R5 first open cycle");
    trial(300, 299, "R5 long blank edge");
    trial(300, 300, "R5 long blank open");
    trial(5,   60,  "R6 floor blanked");
    trial(5,   61,  "R6 floor open");
    trial(0,   61,  "R6 zero code floor");

    // R5 random code/offset pairs.
    for (int k = 0; k < 40; k++) begin
      int c, o;
      c = int'($urandom_range(400, 0));
      o = int'($urandom_range(450, 2));
      trial(c, o, "R5 random trial");
    end

    // R9 fast starter.
    burst_low = 1'b0;
    blank_code = BW'(100);
    t_on = cyc;
    to_off("R9 off before fast starter");
    wait_to(t_on + FAST - 1);
    chk("R9 fast starter not early", gate_on, 0);
    step();
    chk("R9 fast starter fires", gate_on, 1);

    // R10 valley turn-on restarts starter.
    t_on = cyc;
    to_off("R10 off");
    arm_cross = 1'b1; step(); arm_cross = 1'b0;
    wait_to(t_on + 700);
    trig_cross = 1'b1; step(); trig_cross = 1'b0;
    chk("R10 valley turn-on", gate_on, 1);
    t2 = cyc;
    to_off("R10 off again");
    wait_to(t2 + FAST - 1);
    chk("R10 old period did not fire", gate_on, 0);
    step();
    chk("R10 restarted period fires", gate_on, 1);

    // R9 slow starter.
    burst_low = 1'b1;
    t_on = cyc;
    to_off("R9 off before slow starter");
    wait_to(t_on + SLOW - 1);
    chk("R9 slow starter not early", gate_on, 0);
    step();
    chk("R9 slow starter fires", gate_on, 1);

    // R11 disable.
    en = 1'b0;
    step();
    chk("R11 disable clears gate", gate_on, 0);
    burst_low = 1'b0;
    arm_cross = 1'b1; step(); arm_cross = 1'b0;
    trig_cross = 1'b1; step(); trig_cross = 1'b0;
    chk("R11 no valley turn-on while off", gate_on, 0);
    repeat (FAST + 50) step();
    chk("R11 starter silent while off", gate_on, 0);
    en = 1'b1;
    step();
    trig_cross = 1'b1; step(); trig_cross = 1'b0;
    chk("R11 arming cleared by disable", gate_on, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule